// File: doc/BRIEF.md
# Overlapped Serial VRAM Read Sequencer

This block fetches bytes from a video memory built as two banks, each made of two narrow memory chips that are read through a one-bit serial output port per chip. A read goes through three setup cycles, with the address on the bank's own address bus, and then four transfer cycles. In each transfer cycle the block enables that bank's serial outputs and takes one bit from each chip over data lines that both banks share. The two four-bit halves are joined into one byte, which is returned with a one-cycle valid strobe.

Throughput comes from overlap. Each bank has its own address lines and its own output-enable and write-enable lines. This lets the next read be set up on one bank while the other bank is still shifting out the current byte. Reads that alternate between banks therefore keep the shared data lines busy in every cycle, at one byte per four cycles. Two consecutive reads of the same bank cannot overlap, so the second one waits. A mode input picks 64 KB addressing, which uses bank 0 only, or 128 KB addressing, where address bit 16 picks the bank. Requests arrive on a valid/ready handshake. Ready is combinational: it depends on the sequencer state and on the bank of the presented address.

Top module: `vram_serial_reader`

## Requirements
- R1: Synchronous active-high reset drives every bank output enable and `rd_valid_o` low, and a read in flight when reset is asserted produces no byte afterwards.
- R2: With `wide_mode_i` = 1, request address bit 16 selects the bank (0 or 1). The selected bank's address bus carries address bits 15:0, and only that bank's output enable is raised for the read.
- R3: With `wide_mode_i` = 0, every read goes to bank 0 and address bit 16 is ignored. The byte returned is the one stored in bank 0 at address bits 15:0.
- R4: `sd_i[0]` is chip 0 and fills byte bits 7..4. `sd_i[1]` is chip 1 and fills bits 3..0. For each chip, the first bit transferred lands in the highest bit of its nibble.
- R5: A request accepted from idle is followed by three setup cycles, and then by exactly four cycles in which the bank's output enable is high. `sd_i` is sampled at the rising edge that ends each of those cycles. `rd_valid_o` is a one-cycle pulse in the cycle right after the fourth sample, which is 8 cycles after the cycle in which the request was accepted.
- R6: A request to the other bank is accepted in the first transfer cycle of the current read, so ready is low for 3 cycles after an acceptance. Its setup overlaps the remaining transfer cycles, consecutive valid pulses are exactly 4 cycles apart, and at most one bank output enable is high at any time.
- R7: A request to the bank that is currently transferring is held off until that bank's last transfer cycle, so ready is low for 6 cycles after the previous acceptance. Consecutive valid pulses are then 7 cycles apart.
- R8: Bytes return in request order, and ready is low in the cycle right after any acceptance, so at most one setup is ever pending.
- R9: Both bank write enables stay low at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wide_mode_i | input | 1 | 1 selects 128 KB addressing with two banks, 0 selects 64 KB addressing on bank 0 |
| req_valid_i | input | 1 | Read request valid |
| req_addr_i | input | 17 | Byte address of the read |
| req_ready_o | output | 1 | Request accepted at this edge when high together with valid |
| bank_addr_o | output | 2x16 | Per-bank address bus, held from acceptance |
| bank_oe_o | output | 2 | Per-bank serial output enable, active high |
| bank_we_o | output | 2 | Per-bank write enable, active high, always low |
| sd_i | input | 2 | Shared serial data, one bit per chip |
| rd_valid_o | output | 1 | One-cycle strobe for an assembled byte |
| rd_data_o | output | 8 | Assembled byte |

## Verification
The sequencer is driven with four request patterns. A lone read from idle pins down the setup-to-transfer latency and the exact length of the output-enable window. A stream that alternates banks shows whether setup really overlaps the other bank's transfer, since only then are valid pulses four cycles apart with three stall cycles. A stream that stays on one bank must show six stall cycles and a seven-cycle spacing, which separates a correct conflict check from one that lets two reads share a bank. Narrow-mode reads with bit 16 both set and clear, together with a reset asserted during a transfer, show whether bank selection ignores the high bit and whether reset throws away the partial byte.

// File: rtl/svr_pkg.sv
package svr_pkg;
  localparam int unsigned SVR_BANK_AW = 16;  // address bits within one bank
  localparam int unsigned SVR_NBANKS  = 2;   // banks sharing the data lines
  localparam int unsigned SVR_CHIPS   = 2;   // serial chips per bank
  localparam int unsigned SVR_BITS    = 4;   // bits per chip per read
  localparam int unsigned SVR_SETUP   = 3;   // setup cycles per read
endpackage

// File: rtl/svr_sched.sv
module svr_sched #(
  parameter int unsigned NBANKS    = 2,
  parameter int unsigned BANK_W    = 1,
  parameter int unsigned SETUP_CYC = 3,
  parameter int unsigned XFER_BITS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid_i,
  input  logic [BANK_W-1:0] req_bank_i,
  output logic              req_ready_o,
  output logic              accept_o,
  output logic [NBANKS-1:0] xfer_oh_o,
  output logic              xfer_last_o
);
  localparam int unsigned SC_W = (SETUP_CYC > 1) ? $clog2(SETUP_CYC) : 1;
  localparam int unsigned XC_W = (XFER_BITS > 1) ? $clog2(XFER_BITS) : 1;

  logic              setup_on;
  logic [SC_W-1:0]   setup_cnt;
  logic [BANK_W-1:0] setup_bank;
  logic [NBANKS-1:0] xfer_oh;
  logic [XC_W-1:0]   xfer_cnt;
  logic [NBANKS-1:0] req_oh, setup_oh;
  logic              xfer_on, xfer_last, setup_done, fits, same_bank;

  always_comb begin
    req_oh   = '0;
    setup_oh = '0;
    req_oh[req_bank_i]   = 1'b1;
    setup_oh[setup_bank] = 1'b1;
  end

  assign xfer_on    = |xfer_oh;
  assign xfer_last  = xfer_on && (xfer_cnt == XC_W'(XFER_BITS - 1));
  assign setup_done = setup_on && (setup_cnt == SC_W'(SETUP_CYC - 1));
  // a new transfer starts SETUP_CYC+1 cycles after acceptance; it must not
  // begin before the running transfer has shifted out its last bit
  assign fits       = !xfer_on || ((32'(xfer_cnt) + SETUP_CYC + 1) >= XFER_BITS);
  // the same bank cannot take a new address while it is still shifting
  assign same_bank  = |(xfer_oh & req_oh);

  assign req_ready_o = !setup_on && fits && !(same_bank && !xfer_last);
  assign accept_o    = req_valid_i && req_ready_o;
  assign xfer_oh_o   = xfer_oh;
  assign xfer_last_o = xfer_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      setup_on   <= 1'b0;
      setup_cnt  <= '0;
      setup_bank <= '0;
      xfer_oh    <= '0;
      xfer_cnt   <= '0;
    end else begin
      if (accept_o) begin
        setup_on   <= 1'b1;
        setup_cnt  <= '0;
        setup_bank <= req_bank_i;
      end else if (setup_done) begin
        setup_on   <= 1'b0;
      end else if (setup_on) begin
        setup_cnt  <= setup_cnt + 1'b1;
      end

      if (setup_done) begin
        xfer_oh  <= setup_oh;
        xfer_cnt <= '0;
      end else if (xfer_last) begin
        xfer_oh  <= '0;
      end else if (xfer_on) begin
        xfer_cnt <= xfer_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/svr_bank_port.sv
module svr_bank_port #(
  parameter int unsigned BANK_AW = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load_i,
  input  logic [BANK_AW-1:0] addr_i,
  output logic [BANK_AW-1:0] addr_o
);
  // the address is held from acceptance through setup and transfer
  always_ff @(posedge clk) begin
    if (rst)         addr_o <= '0;
    else if (load_i) addr_o <= addr_i;
  end
endmodule

// File: rtl/svr_deser.sv
module svr_deser #(
  parameter int unsigned CHIPS = 2,
  parameter int unsigned BITS  = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  sample_i,
  input  logic                  last_i,
  input  logic [CHIPS-1:0]      sd_i,
  output logic                  valid_o,
  output logic [CHIPS*BITS-1:0] data_o
);
  logic [CHIPS*BITS-1:0] assembled;

  for (genvar c = 0; c < CHIPS; c++) begin : g_chip
    logic [BITS-1:0] sh;
    logic [BITS-1:0] nxt;
    assign nxt = {sh[BITS-2:0], sd_i[c]};
    // chip 0 owns the most significant nibble
    assign assembled[(CHIPS-1-c)*BITS +: BITS] = nxt;
    always_ff @(posedge clk) begin
      if (rst)           sh <= '0;
      else if (sample_i) sh <= nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= sample_i && last_i;
      if (sample_i && last_i) data_o <= assembled;
    end
  end
endmodule

// File: rtl/vram_serial_reader.sv
module vram_serial_reader
  import svr_pkg::*;
#(
  parameter int unsigned BANK_AW   = SVR_BANK_AW,
  parameter int unsigned NBANKS    = SVR_NBANKS,
  parameter int unsigned CHIPS     = SVR_CHIPS,
  parameter int unsigned BITS      = SVR_BITS,
  parameter int unsigned SETUP_CYC = SVR_SETUP,
  parameter int unsigned BANK_W    = (NBANKS > 1) ? $clog2(NBANKS) : 1,
  parameter int unsigned ADDR_W    = BANK_AW + BANK_W,
  parameter int unsigned DATA_W    = CHIPS * BITS
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            wide_mode_i,
  input  logic                            req_valid_i,
  input  logic [ADDR_W-1:0]               req_addr_i,
  output logic                            req_ready_o,
  output logic [NBANKS-1:0][BANK_AW-1:0]  bank_addr_o,
  output logic [NBANKS-1:0]               bank_oe_o,
  output logic [NBANKS-1:0]               bank_we_o,
  input  logic [CHIPS-1:0]                sd_i,
  output logic                            rd_valid_o,
  output logic [DATA_W-1:0]               rd_data_o
);
  logic [BANK_W-1:0] req_bank;
  logic              accept;
  logic [NBANKS-1:0] xfer_oh;
  logic              xfer_last;

  // narrow mode pins everything to bank 0
  assign req_bank  = wide_mode_i ? req_addr_i[BANK_AW +: BANK_W] : '0;
  assign bank_we_o = '0;
  assign bank_oe_o = xfer_oh;

  svr_sched #(
    .NBANKS(NBANKS), .BANK_W(BANK_W), .SETUP_CYC(SETUP_CYC), .XFER_BITS(BITS)
  ) u_sched (
    .clk(clk), .rst(rst),
    .req_valid_i(req_valid_i), .req_bank_i(req_bank),
    .req_ready_o(req_ready_o), .accept_o(accept),
    .xfer_oh_o(xfer_oh), .xfer_last_o(xfer_last)
  );

  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    svr_bank_port #(.BANK_AW(BANK_AW)) u_port (
      .clk(clk), .rst(rst),
      .load_i(accept && (req_bank == BANK_W'(b))),
      .addr_i(req_addr_i[BANK_AW-1:0]),
      .addr_o(bank_addr_o[b])
    );
  end

  svr_deser #(.CHIPS(CHIPS), .BITS(BITS)) u_deser (
    .clk(clk), .rst(rst),
    .sample_i(|xfer_oh), .last_i(xfer_last), .sd_i(sd_i),
    .valid_o(rd_valid_o), .data_o(rd_data_o)
  );
endmodule

// File: rtl/svr_checker.sv
module svr_checker #(
  parameter int unsigned NBANKS = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [NBANKS-1:0] bank_oe,
  input logic              rd_valid
);
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (bank_oe == '0 && !rd_valid));

  a_r6_single_driver: assert property (@(posedge clk) disable iff (rst)
    $onehot0(bank_oe));

  a_r5_valid_pulse: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);

  a_r5_valid_follows_xfer: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(|bank_oe));

  a_r8_one_setup: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);
endmodule

bind vram_serial_reader svr_checker #(.NBANKS(NBANKS)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid_i), .req_ready(req_ready_o),
  .bank_oe(bank_oe_o), .rd_valid(rd_valid_o)
);

// File: tb/tb_vram_serial_reader.sv
module tb_vram_serial_reader;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic             rst, wide, req_valid, req_ready, rd_valid;
  logic [16:0]      req_addr;
  logic [1:0][15:0] bank_addr;
  logic [1:0]       bank_oe, bank_we, sd;
  logic [7:0]       rd_data;

  vram_serial_reader dut (
    .clk(clk), .rst(rst), .wide_mode_i(wide), .req_valid_i(req_valid),
    .req_addr_i(req_addr), .req_ready_o(req_ready), .bank_addr_o(bank_addr),
    .bank_oe_o(bank_oe), .bank_we_o(bank_we), .sd_i(sd),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data)
  );

  int cyc = 0;
  int tests = 0, fails = 0;
  int oe_cnt0 = 0, oe_cnt1 = 0, we_hits = 0, valid_total = 0;
  int last_stall = 0, last_acc = 0;
  logic [7:0] expq[$];
  int vt[$];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] mem_byte(input int b, input logic [15:0] a);
    return 8'(a[7:0] * 8'd29) ^ a[15:8] ^ ((b != 0) ? 8'hA5 : 8'h3C);
  endfunction

  // memory model: each bank shifts its byte out while its enable is high
  logic [1:0] c0 = 2'd0, c1 = 2'd0;
  logic [7:0] m0, m1;
  assign m0 = mem_byte(0, bank_addr[0]);
  assign m1 = mem_byte(1, bank_addr[1]);
  always @(posedge clk) begin
    c0 <= bank_oe[0] ? c0 + 2'd1 : 2'd0;
    c1 <= bank_oe[1] ? c1 + 2'd1 : 2'd0;
  end
  assign sd[0] = bank_oe[0] ? m0[3'd7 - {1'b0, c0}] : bank_oe[1] ? m1[3'd7 - {1'b0, c1}] : 1'b0;
  assign sd[1] = bank_oe[0] ? m0[3'd3 - {1'b0, c0}] : bank_oe[1] ? m1[3'd3 - {1'b0, c1}] : 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (bank_oe[0]) oe_cnt0++;
      if (bank_oe[1]) oe_cnt1++;
      if (bank_we != 2'b00) we_hits++;
      if (rd_valid) begin
        logic [7:0] e;
        valid_total++;
        vt.push_back(cyc);
        if (expq.size() == 0) chk(1'b0, "R8 unexpected byte", rd_data, -1);
        else begin
          e = expq.pop_front();
          chk(rd_data == e, "R4 byte value (R2/R3 bank)", rd_data, e);
        end
      end
    end
  end

  task automatic issue(input logic [16:0] a);
    int st;
    st = 0;
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    #1;
    while (!req_ready) begin
      st++;
      @(negedge clk);
      #1;
    end
    last_stall = st;
    last_acc   = cyc;
    expq.push_back(mem_byte(wide ? int'(a[16]) : 0, a[15:0]));
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (expq.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL R8 watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int n;
    rst = 1'b1; wide = 1'b0; req_valid = 1'b0; req_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(bank_oe == 2'b00, "R1 oe in reset", bank_oe, 0);
    chk(bank_we == 2'b00, "R9 we in reset", bank_we, 0);
    chk(!rd_valid, "R1 valid in reset", rd_valid, 0);
    rst = 1'b0;
    @(negedge clk);
    #1;
    chk(req_ready, "R8 ready when idle", req_ready, 1);

    // single wide read from idle, bank 1
    wide = 1'b1; oe_cnt0 = 0; oe_cnt1 = 0; vt.delete();
    issue(17'h1_2345);
    idle();
    drain();
    chk(vt.size() == 1, "R8 one byte", vt.size(), 1);
    if (vt.size() == 1) chk(vt[0] - last_acc == 8, "R5 latency", vt[0] - last_acc, 8);
    chk(oe_cnt1 == 4, "R5 oe window", oe_cnt1, 4);
    chk(oe_cnt0 == 0, "R2 other bank idle", oe_cnt0, 0);
    chk(bank_addr[1] == 16'h2345, "R2 bank address", bank_addr[1], 16'h2345);

    // alternating banks
    vt.delete();
    for (int i = 0; i < 8; i++) begin
      issue({i[0], 16'(i * 977 + 5)});
      if (i > 0) chk(last_stall == 3, "R6 stall cycles", last_stall, 3);
    end
    idle();
    drain();
    chk(vt.size() == 8, "R8 byte count", vt.size(), 8);
    for (int i = 1; i < 8 && i < vt.size(); i++)
      chk(vt[i] - vt[i-1] == 4, "R6 gap-free spacing", vt[i] - vt[i-1], 4);

    // same bank back to back
    vt.delete();
    for (int i = 0; i < 4; i++) begin
      issue({1'b0, 16'(i * 4099 + 1)});
      if (i > 0) chk(last_stall == 6, "R7 stall cycles", last_stall, 6);
    end
    idle();
    drain();
    for (int i = 1; i < 4 && i < vt.size(); i++)
      chk(vt[i] - vt[i-1] == 7, "R7 spacing", vt[i] - vt[i-1], 7);

    // narrow mode with bit 16 toggling
    wide = 1'b0; oe_cnt0 = 0; oe_cnt1 = 0; vt.delete();
    for (int i = 0; i < 4; i++) issue({i[0], 16'(i * 313 + 77)});
    idle();
    drain();
    chk(oe_cnt1 == 0, "R3 bank 1 unused", oe_cnt1, 0);
    chk(oe_cnt0 == 16, "R3 bank 0 cycles", oe_cnt0, 16);
    for (int i = 1; i < 4 && i < vt.size(); i++)
      chk(vt[i] - vt[i-1] == 7, "R3 same-bank spacing", vt[i] - vt[i-1], 7);

    // reset during a transfer
    wide = 1'b1;
    issue(17'h0_0100);
    idle();
    repeat (4) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(bank_oe == 2'b00, "R1 oe cleared", bank_oe, 0);
    expq.delete();
    n = valid_total;
    rst = 1'b0;
    repeat (12) @(negedge clk);
    chk(valid_total == n, "R1 in-flight discarded", valid_total - n, 0);
    chk(bank_oe == 2'b00, "R1 oe stays low", bank_oe, 0);

    chk(we_hits == 0, "R9 write enable low", we_hits, 0);
    finish_run();
  end
endmodule